// File: doc/BRIEF.md
# Sectioned Control Register Access Controller

This block sits behind a byte-oriented serial protocol engine and decides what each byte access to a small control and clock register space does. The register space is split into five sections of different sizes: two alarm banks, a control pair, a clock bank and a single status byte. When the engine presents the byte that opens an operation, the block checks whether that byte targets this register space. It then keeps an address pointer across the operation's address load, reads and writes.

Sequential reads and page writes stay inside the section where they start and wrap back to that section's first byte. Written bytes are collected in a page buffer and reach storage only when the operation ends with a stop. All bytes are committed in one cycle as a masked page. Writes to every section except status are refused unless a two-step enable has been completed through the status byte. Accesses that break the rules raise a terminate flag, and the rest of the operation is then ignored.

Top module: `ccr_access_ctrl`

## Requirements
- R1: An operation is opened by `dev_sel_i` with `dev_byte_i` matching 1101111x (bit 0 is don't-care). Any other byte leaves the block deselected, and later address loads, reads, writes and stops in that operation neither move `rd_addr_o` nor produce `commit_o`.
- R2: Valid addresses are 0x00–0x07 (alarm 0), 0x08–0x0F (alarm 1), 0x10–0x11 (control), 0x30–0x37 (clock) and 0x3F (status). Loading any other address sets `term_o` and leaves `rd_addr_o` unchanged.
- R3: Each accepted read or write advances the pointer by one. After the last byte of a section it returns to the section's first byte, for example 0x37 to 0x30, 0x11 to 0x10 and 0x0F to 0x08.
- R4: The pointer is kept across a stop and a new device select. A read without an address load continues at the previous address plus one.
- R5: In the status section, the first byte of an operation is accepted. A second read or write in the same operation sets `term_o`, does not advance the pointer, and discards the buffered write.
- R6: Written bytes are buffered by their offset within the section. `commit_o` pulses for one cycle, right after the stop edge of a non-terminated operation that wrote at least one byte. It carries the section base on `commit_base_o`, a bit for each written offset on `commit_mask_o`, and byte k on `commit_data_o[8k+7:8k]`.
- R7: A buffered write to any section other than status is committed only if both `wel_o` and `rwel_o` are 1 at the stop. Otherwise it is dropped and no `commit_o` occurs.
- R8: A status write is always committed. Committed value 0x02 gives `wel_o`=1 and `rwel_o`=0. Value 0x06 gives both bits 1 if `wel_o` was already 1. Any other value, including 0x06 while `wel_o` is 0, clears both bits.
- R9: A write in an operation that has not loaded a valid address sets `term_o`.
- R10: After reset, `rd_addr_o`=0x00 and `term_o`, `wel_o`, `rwel_o` and `commit_o` are all 0.
- R11: Once `term_o` is set, it stays set until the next device select. Until then, reads and writes do not move the pointer and a stop commits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_sel_i | input | 1 | Strobe: device-select byte present |
| dev_byte_i | input | 8 | Device-select byte |
| addr_load_i | input | 1 | Strobe: address byte present |
| addr_i | input | 8 | Address byte |
| rd_i | input | 1 | Strobe: one byte read at `rd_addr_o` |
| wr_i | input | 1 | Strobe: one byte written at the pointer |
| wr_data_i | input | 8 | Write data byte |
| stop_i | input | 1 | Strobe: stop condition, ends the operation |
| rd_addr_o | output | 8 | Current address pointer |
| term_o | output | 1 | Access terminated |
| wel_o | output | 1 | First enable step done |
| rwel_o | output | 1 | Second enable step done |
| commit_o | output | 1 | One-cycle page commit pulse |
| commit_base_o | output | 8 | Base address of committed section |
| commit_mask_o | output | 8 | Written-offset mask |
| commit_data_o | output | 64 | Committed bytes by offset |

## Verification
Sequential reads start near the end of the clock and control sections, so wrap to the section base can be told apart from running on into the next address. A page write starts two bytes before the end of alarm 1. The committed mask and byte lanes then show whether the data landed at wrapped offsets. Status writes of 0x02, 0x06, 0x55 and an out-of-order 0x06 separate the enable sequence from a write of any other value. Protected writes before and after the enable show that the gate is applied at the stop. Gap addresses, writes without an address, and repeated status access each separate a terminated operation from one that is only deselected.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam logic [7:0] SEL_PAT  = 8'hDE;
  localparam logic [7:0] SEL_MASK = 8'hFE;

  localparam addr_t AL0_BASE = 8'h00;
  localparam addr_t AL1_BASE = 8'h08;
  localparam addr_t CTL_BASE = 8'h10;
  localparam addr_t RTC_BASE = 8'h30;
  localparam addr_t STS_BASE = 8'h3F;

  typedef enum logic [2:0] {SEC_AL0, SEC_AL1, SEC_CTL, SEC_RTC, SEC_STS, SEC_NONE} sec_e;

  function automatic sec_e sec_of(input addr_t a);
    if (a < AL1_BASE)                        return SEC_AL0;
    else if (a < CTL_BASE)                   return SEC_AL1;
    else if (a < CTL_BASE + 8'd2)            return SEC_CTL;
    else if (a >= RTC_BASE && a < RTC_BASE + 8'd8) return SEC_RTC;
    else if (a == STS_BASE)                  return SEC_STS;
    else                                     return SEC_NONE;
  endfunction

  function automatic addr_t sec_base(input sec_e s);
    case (s)
      SEC_AL1: return AL1_BASE;
      SEC_CTL: return CTL_BASE;
      SEC_RTC: return RTC_BASE;
      SEC_STS: return STS_BASE;
      default: return AL0_BASE;
    endcase
  endfunction

  function automatic addr_t sec_size(input sec_e s);
    case (s)
      SEC_CTL:  return 8'd2;
      SEC_STS:  return 8'd1;
      SEC_NONE: return 8'd1;
      default:  return 8'd8;
    endcase
  endfunction

  // next address with wrap inside the section
  function automatic addr_t next_addr(input addr_t a);
    sec_e  s;
    addr_t off;
    s   = sec_of(a);
    off = a - sec_base(s);
    if (off + 8'd1 == sec_size(s)) return sec_base(s);
    return a + 8'd1;
  endfunction
endpackage

// File: rtl/ccr_addr_ptr.sv
module ccr_addr_ptr
  import ccr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  addr_t load_addr_i,
  input  logic  step_i,
  output addr_t ptr_o,
  output sec_e  sec_o
);
  addr_t ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_addr_i;
    else if (step_i) ptr_q <= next_addr(ptr_q);
  end

  assign ptr_o = ptr_q;
  assign sec_o = sec_of(ptr_q);

  assert_step_stays_in_section_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (sec_of(ptr_q) == $past(sec_of(ptr_q))));
endmodule

// File: rtl/ccr_wr_buffer.sv
module ccr_wr_buffer
  import ccr_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned PAGE = 8,
  localparam int unsigned OW  = $clog2(PAGE)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               wr_i,
  input  logic [OW-1:0]      off_i,
  input  logic [DW-1:0]      data_i,
  input  addr_t              base_i,
  input  logic               commit_i,
  output logic               any_o,
  output addr_t              base_o,
  output logic [DW-1:0]      slot0_o,
  output logic               commit_o,
  output addr_t              commit_base_o,
  output logic [PAGE-1:0]    commit_mask_o,
  output logic [PAGE*DW-1:0] commit_data_o
);
  logic [PAGE-1:0]    mask_q;
  logic [PAGE*DW-1:0] data_q;
  addr_t              base_q;

  for (genvar i = 0; i < PAGE; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[i]              <= 1'b0;
        data_q[i*DW +: DW]     <= '0;
      end else if (clear_i) begin
        mask_q[i]              <= 1'b0;
      end else if (wr_i && off_i == OW'(i)) begin
        mask_q[i]              <= 1'b1;
        data_q[i*DW +: DW]     <= data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q        <= '0;
      commit_o      <= 1'b0;
      commit_base_o <= '0;
      commit_mask_o <= '0;
      commit_data_o <= '0;
    end else begin
      if (wr_i && !clear_i) base_q <= base_i;
      commit_o <= commit_i;
      if (commit_i) begin
        commit_base_o <= base_q;
        commit_mask_o <= mask_q;
        commit_data_o <= data_q;
      end
    end
  end

  assign any_o   = |mask_q;
  assign base_o  = base_q;
  assign slot0_o = data_q[DW-1:0];

  assert_commit_has_bytes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (commit_mask_o != '0));
endmodule

// File: rtl/ccr_wen_guard.sv
module ccr_wen_guard #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sts_wr_i,
  input  logic [DW-1:0] sts_data_i,
  output logic          wel_o,
  output logic          rwel_o
);
  localparam logic [DW-1:0] STEP1 = DW'(8'h02);
  localparam logic [DW-1:0] STEP2 = DW'(8'h06);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o  <= 1'b0;
      rwel_o <= 1'b0;
    end else if (sts_wr_i) begin
      if (sts_data_i == STEP1) begin
        wel_o  <= 1'b1;
        rwel_o <= 1'b0;
      end else if (sts_data_i == STEP2 && wel_o) begin
        wel_o  <= 1'b1;
        rwel_o <= 1'b1;
      end else begin
        wel_o  <= 1'b0;
        rwel_o <= 1'b0;
      end
    end
  end

  assert_rwel_needs_wel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rwel_o) |-> $past(wel_o));
endmodule

// File: rtl/ccr_access_ctrl.sv
module ccr_access_ctrl
  import ccr_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned PAGE = 8,
  localparam int unsigned OW  = $clog2(PAGE)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dev_sel_i,
  input  logic [7:0]         dev_byte_i,
  input  logic               addr_load_i,
  input  logic [7:0]         addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic               stop_i,
  output logic [7:0]         rd_addr_o,
  output logic               term_o,
  output logic               wel_o,
  output logic               rwel_o,
  output logic               commit_o,
  output logic [7:0]         commit_base_o,
  output logic [PAGE-1:0]    commit_mask_o,
  output logic [PAGE*DW-1:0] commit_data_o
);
  logic  op_sel_q, term_q, addr_ok_q, sts_hit_q;
  addr_t ptr;
  sec_e  ptr_sec;
  addr_t off_full;
  logic  buf_any, buf_sts;
  addr_t buf_base;
  logic [DW-1:0] buf_slot0;

  logic sel_hit, live, acc, ld, bad_ld, sts_again, wr_noaddr, viol, do_acc;
  logic stop_ev, commit_go, buf_clear;

  assign sel_hit   = (dev_byte_i & SEL_MASK) == SEL_PAT;
  assign live      = op_sel_q & ~term_q & ~stop_i & ~dev_sel_i;
  assign acc       = (rd_i | wr_i) & live;
  assign ld        = addr_load_i & live;
  assign bad_ld    = ld & (sec_of(addr_i) == SEC_NONE);
  assign sts_again = acc & (ptr_sec == SEC_STS) & sts_hit_q;
  assign wr_noaddr = acc & wr_i & ~addr_ok_q;
  assign viol      = sts_again | wr_noaddr | bad_ld;
  assign do_acc    = acc & ~sts_again & ~wr_noaddr;

  assign stop_ev   = stop_i & op_sel_q & ~term_q;
  assign buf_sts   = buf_base == STS_BASE;
  assign commit_go = stop_ev & buf_any & (buf_sts | (wel_o & rwel_o));
  assign buf_clear = dev_sel_i | stop_i | viol | ld;
  assign off_full  = ptr - sec_base(ptr_sec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_sel_q  <= 1'b0;
      term_q    <= 1'b0;
      addr_ok_q <= 1'b0;
      sts_hit_q <= 1'b0;
    end else if (dev_sel_i) begin
      op_sel_q  <= sel_hit;
      term_q    <= 1'b0;
      addr_ok_q <= 1'b0;
      sts_hit_q <= 1'b0;
    end else if (stop_i) begin
      op_sel_q  <= 1'b0;
    end else begin
      if (viol) term_q <= 1'b1;
      if (ld && !bad_ld) begin
        addr_ok_q <= 1'b1;
        sts_hit_q <= 1'b0;
      end else if (do_acc && ptr_sec == SEC_STS) begin
        sts_hit_q <= 1'b1;
      end
    end
  end

  ccr_addr_ptr i_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ld & ~bad_ld),
    .load_addr_i (addr_i),
    .step_i      (do_acc),
    .ptr_o       (ptr),
    .sec_o       (ptr_sec)
  );

  ccr_wr_buffer #(.DW(DW), .PAGE(PAGE)) i_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (buf_clear),
    .wr_i          (do_acc & wr_i),
    .off_i         (off_full[OW-1:0]),
    .data_i        (wr_data_i),
    .base_i        (sec_base(ptr_sec)),
    .commit_i      (commit_go),
    .any_o         (buf_any),
    .base_o        (buf_base),
    .slot0_o       (buf_slot0),
    .commit_o      (commit_o),
    .commit_base_o (commit_base_o),
    .commit_mask_o (commit_mask_o),
    .commit_data_o (commit_data_o)
  );

  ccr_wen_guard #(.DW(DW)) i_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sts_wr_i   (commit_go & buf_sts),
    .sts_data_i (buf_slot0),
    .wel_o      (wel_o),
    .rwel_o     (rwel_o)
  );

  assign rd_addr_o = ptr;
  assign term_o    = term_q;

  assert_term_blocks_commit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> !commit_o);
  assert_protected_needs_rwel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && commit_base_o != STS_BASE) |-> (wel_o && rwel_o));
  assert_sts_second_term_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ptr_sec == SEC_STS && sts_hit_q) |=> (term_o && $stable(rd_addr_o)));
  assert_bad_addr_holds_ptr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_ld |=> (term_o && $stable(rd_addr_o)));
endmodule

// File: tb/test_ccr_access_ctrl.sv
module test_ccr_access_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_sel = 1'b0, addr_load = 1'b0, rd = 1'b0, wr = 1'b0, stop = 1'b0;
  logic [7:0]  dev_byte = '0, addr = '0, wdata = '0;
  logic [7:0]  rd_addr, commit_base, commit_mask;
  logic        term, wel, rwel, commit;
  logic [63:0] commit_data;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  ccr_access_ctrl i_ccr_access_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dev_sel_i(dev_sel), .dev_byte_i(dev_byte),
    .addr_load_i(addr_load), .addr_i(addr), .rd_i(rd), .wr_i(wr), .wr_data_i(wdata),
    .stop_i(stop), .rd_addr_o(rd_addr), .term_o(term), .wel_o(wel), .rwel_o(rwel),
    .commit_o(commit), .commit_base_o(commit_base), .commit_mask_o(commit_mask),
    .commit_data_o(commit_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic sel(input logic [7:0] b);
    @(negedge clk); dev_sel = 1'b1; dev_byte = b;
    @(negedge clk); dev_sel = 1'b0;
  endtask
  task automatic ld(input logic [7:0] a);
    @(negedge clk); addr_load = 1'b1; addr = a;
    @(negedge clk); addr_load = 1'b0;
  endtask
  task automatic rdb();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask
  task automatic wrb(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask
  // returns with commit_o visible for the cycle after the stop edge
  task automatic stp();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 rd_addr", rd_addr, 8'h00);
    chk("R10 term", term, 0);
    chk("R10 wel", wel, 0);
    chk("R10 rwel", rwel, 0);
    chk("R10 commit", commit, 0);
  endtask

  task automatic t_devsel();
    sel(8'hA0); ld(8'h08); rdb();
    chk("R1 foreign select keeps ptr", rd_addr, 8'h00);
    wrb(8'h33); stp();
    chk("R1 foreign select no commit", commit, 0);
    sel(8'hDF); ld(8'h08);
    chk("R1 match with bit0 set", rd_addr, 8'h08);
    stp();
  endtask

  task automatic t_seq_read();
    sel(8'hDE); ld(8'h36);
    chk("R3 start", rd_addr, 8'h36); rdb();
    chk("R3 step", rd_addr, 8'h37); rdb();
    chk("R3 clock wrap", rd_addr, 8'h30); rdb();
    chk("R3 after wrap", rd_addr, 8'h31); stp();
    sel(8'hDE); ld(8'h11); rdb();
    chk("R3 control wrap", rd_addr, 8'h10); stp();
  endtask

  task automatic t_cur_read();
    sel(8'hDE); ld(8'h31); rdb(); stp();
    sel(8'hDE);
    chk("R4 current address kept", rd_addr, 8'h32); rdb();
    chk("R4 continues", rd_addr, 8'h33); stp();
  endtask

  task automatic t_bad_addr();
    sel(8'hDE); ld(8'h20);
    chk("R2 gap term", term, 1);
    chk("R2 gap ptr", rd_addr, 8'h33); stp();
    sel(8'hDE);
    chk("R11 select clears term", term, 0);
    ld(8'h40);
    chk("R2 high term", term, 1);
    chk("R2 high ptr", rd_addr, 8'h33); stp();
  endtask

  task automatic t_term_ignore();
    sel(8'hDE); wrb(8'h12);
    chk("R9 write without address", term, 1);
    rdb();
    chk("R11 read ignored", rd_addr, 8'h33);
    stp();
    chk("R11 no commit", commit, 0);
    chk("R11 term held", term, 1);
  endtask

  task automatic t_protect();
    sel(8'hDE); ld(8'h00); wrb(8'h11); stp();
    chk("R7 dropped without enable", commit, 0);
  endtask

  task automatic t_enable();
    sel(8'hDE); ld(8'h3F); wrb(8'h02); stp();
    chk("R8 status commit", commit, 1);
    chk("R8 status base", commit_base, 8'h3F);
    chk("R8 status mask", commit_mask, 8'h01);
    chk("R8 step1 wel", wel, 1);
    chk("R8 step1 rwel", rwel, 0);
    sel(8'hDE); ld(8'h3F); wrb(8'h06); stp();
    chk("R8 step2 wel", wel, 1);
    chk("R8 step2 rwel", rwel, 1);
  endtask

  task automatic t_page_write();
    sel(8'hDE); ld(8'h0E); wrb(8'hAA); wrb(8'hBB); wrb(8'hCC);
    chk("R3 page write wrap ptr", rd_addr, 8'h09);
    stp();
    chk("R6 commit pulse", commit, 1);
    chk("R6 base", commit_base, 8'h08);
    chk("R6 mask", commit_mask, 8'hC1);
    chk("R6 slot0", commit_data[7:0], 8'hCC);
    chk("R6 slot6", commit_data[55:48], 8'hAA);
    chk("R6 slot7", commit_data[63:56], 8'hBB);
    @(negedge clk);
    chk("R6 single pulse", commit, 0);
  endtask

  task automatic t_status_term();
    sel(8'hDE); ld(8'h3F); wrb(8'h02);
    chk("R5 first status byte", term, 0);
    chk("R5 ptr stays at status", rd_addr, 8'h3F);
    wrb(8'h00);
    chk("R5 second byte term", term, 1);
    stp();
    chk("R5 discarded", commit, 0);
    chk("R5 wel kept", wel, 1);
    chk("R5 rwel kept", rwel, 1);
    sel(8'hDE); ld(8'h3F); rdb(); rdb();
    chk("R5 second read term", term, 1);
    stp();
  endtask

  task automatic t_clear();
    sel(8'hDE); ld(8'h3F); wrb(8'h55); stp();
    chk("R8 other value clears wel", wel, 0);
    chk("R8 other value clears rwel", rwel, 0);
    sel(8'hDE); ld(8'h3F); wrb(8'h06); stp();
    chk("R8 step2 out of order rwel", rwel, 0);
    sel(8'hDE); ld(8'h32); wrb(8'h44); stp();
    chk("R7 dropped after clear", commit, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_devsel();
    t_seq_read();
    t_cur_read();
    t_bad_addr();
    t_term_ignore();
    t_protect();
    t_enable();
    t_page_write();
    t_status_term();
    t_clear();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule